// File: doc/BRIEF.md
# Flash Write-Status Responder with Erase Suspend

This block models the device side of a flash array's write-status reporting. While an embedded program or erase runs, a status read returns one polling bit per byte lane. The bit shows whether the operation has finished. The block receives decoded command strobes and a completion strobe from an external busy counter. It keeps the operating mode, the programmed target value and the last completed array value. From these it produces the per-lane polling bits, a busy flag and the current mode.

The block follows these rules. A program reports the complement of each lane's most significant bit until it completes, and the true bit afterwards. An erase reports 0 until it completes or is suspended, and reports 1 from then on. An erase may be suspended, may be resumed, and may take a program while suspended. A program or erase aimed at a protected target does not change the array. Instead, polling stays active for a fixed number of clock cycles, and then the device returns to array read. Both window lengths are parameters, set to about 1 us and about 100 us at the clock rate in use.

Top module: `flash_status_resp`

## Requirements
- R1: After reset the mode is array read (code 0), `busy_o` is 0 and every polling bit is 1.
- R2: An unprotected program accepted from array read enters mode 1, raises `busy_o` and returns, on polling bit i, the complement of bit `i*LANE_W+LANE_W-1` of the program data.
- R3: `op_done_i` ends a running program. The mode returns to 0, `busy_o` falls, and each polling bit shows the true programmed bit.
- R4: An unprotected erase enters mode 2 with `busy_o` high and all polling bits 0. `op_done_i` returns the mode to 0 with all polling bits 1.
- R5: Suspend during an erase enters mode 3. `busy_o` goes to 0 and all polling bits read 1.
- R6: Resume in mode 3 returns to mode 2 with polling bits 0. Resume in any other mode leaves the mode unchanged.
- R7: Suspend is accepted again after a resume. Suspend while no erase runs leaves the mode unchanged.
- R8: An unprotected program in mode 3 enters mode 4, which reports busy and complemented data. Its completion returns to mode 3 with polling bits 1.
- R9: A protected program from array read holds mode 5 with complemented polling for exactly `PGM_WIN` cycles, ignores `op_done_i`, then returns to mode 0 with the array value unchanged.
- R10: A protected erase from array read holds mode 6 with polling bits 0 for exactly `ERS_WIN` cycles, then returns to mode 0 with the array value unchanged.
- R11: Entering identification while in mode 3 gives mode 7, in which polling bits read 1 and resume is ignored. Leaving identification returns to mode 3.
- R12: A protected program in mode 3 is ignored. A program or erase command during a running program or erase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pgm_cmd_i | input | 1 | Decoded program command strobe |
| ers_cmd_i | input | 1 | Decoded erase command strobe |
| susp_cmd_i | input | 1 | Erase suspend strobe |
| resm_cmd_i | input | 1 | Erase resume strobe |
| id_enter_i | input | 1 | Enter identification mode strobe |
| id_exit_i | input | 1 | Leave identification mode strobe |
| prot_i | input | 1 | Target sector is protected |
| pgm_data_i | input | LANES*LANE_W | Data being programmed |
| op_done_i | input | 1 | Operation complete strobe from the busy counter |
| poll_o | output | LANES | Polling bit per lane |
| busy_o | output | 1 | Embedded operation or protected window active |
| mode_o | output | 3 | Current mode code |

## Verification
The bench programs all 16 patterns of lane MSBs and checks both the complemented phase and the true phase. A design that skips the inversion, or inverts the wrong bit position, fails on the asymmetric patterns. The protected windows are counted cycle by cycle while `op_done_i` is held high, so an off-by-one counter or a window that the completion strobe cuts short shows up as a mode mismatch at the boundary sample. The bench also goes through the suspend cycle several times: resume, a second suspend, resume outside suspend, identification entry and exit, and programs during suspend. A design that loses the erase context, or accepts stray strobes, ends in the wrong mode code.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    MD_READ     = 3'd0,
    MD_PGM      = 3'd1,
    MD_ERS      = 3'd2,
    MD_SUSP     = 3'd3,
    MD_SUSP_PGM = 3'd4,
    MD_PROT_PGM = 3'd5,
    MD_PROT_ERS = 3'd6,
    MD_SUSP_ID  = 3'd7
  } mode_e;
endpackage

// File: rtl/flash_prot_timer.sv
module flash_prot_timer #(
  parameter int PGM_WIN = 100,
  parameter int ERS_WIN = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ers_sel_i,
  output logic expire_o
);
  localparam int MAXW = (PGM_WIN > ERS_WIN) ? PGM_WIN : ERS_WIN;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= ers_sel_i ? CW'(ERS_WIN - 1) : CW'(PGM_WIN - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = act_q && (cnt_q == '0);

  a_r10_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q <= CW'(MAXW - 1)));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !expire_o) |=> act_q);
endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
  import flash_status_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pgm_i,
  input  logic             ers_i,
  input  logic             susp_i,
  input  logic             resm_i,
  input  logic             id_enter_i,
  input  logic             id_exit_i,
  input  logic             prot_i,
  input  logic             done_i,
  input  logic             expire_i,
  input  logic [LANES-1:0] msb_i,
  output mode_e            mode_o,
  output logic [LANES-1:0] tgt_o,
  output logic [LANES-1:0] arr_o,
  output logic             prot_start_o,
  output logic             prot_ers_o
);
  mode_e            mode_q, mode_d;
  logic [LANES-1:0] tgt_q, arr_q;
  logic             latch_tgt, load_arr, erase_arr;

  always_comb begin
    mode_d       = mode_q;
    latch_tgt    = 1'b0;
    load_arr     = 1'b0;
    erase_arr    = 1'b0;
    prot_start_o = 1'b0;
    prot_ers_o   = 1'b0;
    unique case (mode_q)
      MD_READ: begin
        if (pgm_i) begin
          latch_tgt = 1'b1;
          if (prot_i) begin
            mode_d       = MD_PROT_PGM;
            prot_start_o = 1'b1;
          end else mode_d = MD_PGM;
        end else if (ers_i) begin
          if (prot_i) begin
            mode_d       = MD_PROT_ERS;
            prot_start_o = 1'b1;
            prot_ers_o   = 1'b1;
          end else mode_d = MD_ERS;
        end
      end
      MD_PGM: if (done_i) begin
        mode_d   = MD_READ;
        load_arr = 1'b1;
      end
      MD_ERS: begin
        if (done_i) begin
          mode_d    = MD_READ;
          erase_arr = 1'b1;
        end else if (susp_i) mode_d = MD_SUSP;
      end
      MD_SUSP: begin
        if (resm_i) mode_d = MD_ERS;
        else if (pgm_i && !prot_i) begin
          mode_d    = MD_SUSP_PGM;
          latch_tgt = 1'b1;
        end else if (id_enter_i) mode_d = MD_SUSP_ID;
      end
      MD_SUSP_PGM: if (done_i) begin
        mode_d   = MD_SUSP;
        load_arr = 1'b1;
      end
      MD_PROT_PGM, MD_PROT_ERS: if (expire_i) mode_d = MD_READ;
      MD_SUSP_ID: if (id_exit_i) mode_d = MD_SUSP;
      default: mode_d = MD_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_READ;
      tgt_q  <= '1;
      arr_q  <= '1;
    end else begin
      mode_q <= mode_d;
      if (latch_tgt) tgt_q <= msb_i;
      if (load_arr)       arr_q <= tgt_q;
      else if (erase_arr) arr_q <= '1;
    end
  end

  assign mode_o = mode_q;
  assign tgt_o  = tgt_q;
  assign arr_o  = arr_q;

  a_r5_susp_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_ERS && susp_i && !done_i) |=> (mode_q == MD_SUSP));
  a_r9_window_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MD_PROT_PGM || mode_q == MD_PROT_ERS) && !expire_i) |=> (mode_q == $past(mode_q)));
  a_r11_id_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_SUSP_ID && id_exit_i) |=> (mode_q == MD_SUSP));
  a_r10_arr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MD_PROT_ERS || mode_q == MD_PROT_PGM) |=> $stable(arr_q));
endmodule

// File: rtl/flash_poll_mux.sv
module flash_poll_mux
  import flash_status_pkg::*;
#(
  parameter int LANES = 4
) (
  input  mode_e            mode_i,
  input  logic [LANES-1:0] tgt_i,
  input  logic [LANES-1:0] arr_i,
  output logic [LANES-1:0] poll_o,
  output logic             busy_o
);
  always_comb begin
    unique case (mode_i)
      MD_PGM, MD_SUSP_PGM, MD_PROT_PGM: poll_o = ~tgt_i;
      MD_ERS, MD_PROT_ERS:              poll_o = '0;
      MD_SUSP, MD_SUSP_ID:              poll_o = '1;
      default:                          poll_o = arr_i;
    endcase
  end

  assign busy_o = (mode_i == MD_PGM) || (mode_i == MD_ERS) || (mode_i == MD_SUSP_PGM) ||
                  (mode_i == MD_PROT_PGM) || (mode_i == MD_PROT_ERS);
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_status_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int PGM_WIN = 100,
  parameter int ERS_WIN = 10000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pgm_cmd_i,
  input  logic                    ers_cmd_i,
  input  logic                    susp_cmd_i,
  input  logic                    resm_cmd_i,
  input  logic                    id_enter_i,
  input  logic                    id_exit_i,
  input  logic                    prot_i,
  input  logic [LANES*LANE_W-1:0] pgm_data_i,
  input  logic                    op_done_i,
  output logic [LANES-1:0]        poll_o,
  output logic                    busy_o,
  output logic [2:0]              mode_o
);
  logic [LANES-1:0] msb, tgt, arr;
  logic             expire, prot_start, prot_ers;
  mode_e            mode;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign msb[g] = pgm_data_i[g*LANE_W + LANE_W - 1];
  end

  flash_mode_fsm #(.LANES(LANES)) u_fsm (
    .clk_i, .rst_ni,
    .pgm_i(pgm_cmd_i), .ers_i(ers_cmd_i), .susp_i(susp_cmd_i), .resm_i(resm_cmd_i),
    .id_enter_i, .id_exit_i, .prot_i, .done_i(op_done_i), .expire_i(expire),
    .msb_i(msb), .mode_o(mode), .tgt_o(tgt), .arr_o(arr),
    .prot_start_o(prot_start), .prot_ers_o(prot_ers)
  );

  flash_prot_timer #(.PGM_WIN(PGM_WIN), .ERS_WIN(ERS_WIN)) u_timer (
    .clk_i, .rst_ni, .start_i(prot_start), .ers_sel_i(prot_ers), .expire_o(expire)
  );

  flash_poll_mux #(.LANES(LANES)) u_mux (
    .mode_i(mode), .tgt_i(tgt), .arr_i(arr), .poll_o, .busy_o
  );

  assign mode_o = mode;

  a_r4_erase_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_ERS) |-> (poll_o == '0));
  a_r2_pgm_compl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_PGM) |-> (poll_o == ~tgt));
  a_r5_susp_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_SUSP) |-> (!busy_o && poll_o == '1));
endmodule

// File: tb/flash_status_resp_tb_top.sv
module flash_status_resp_tb_top;
  localparam int LANES = 4, LANE_W = 8, PGM_WIN = 5, ERS_WIN = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pgm = 0, ers = 0, susp = 0, resm = 0, iden = 0, idex = 0, prot = 0, done = 0;
  logic [LANES*LANE_W-1:0] data = '0;
  logic [LANES-1:0] poll;
  logic busy;
  logic [2:0] mode;
  int vec = 0, bad = 0;
  logic [LANES-1:0] exp_arr;

  always #5 clk = ~clk;

  flash_status_resp #(.LANES(LANES), .LANE_W(LANE_W), .PGM_WIN(PGM_WIN), .ERS_WIN(ERS_WIN)) dut_i (
    .clk_i(clk), .rst_ni, .pgm_cmd_i(pgm), .ers_cmd_i(ers), .susp_cmd_i(susp), .resm_cmd_i(resm),
    .id_enter_i(iden), .id_exit_i(idex), .prot_i(prot), .pgm_data_i(data), .op_done_i(done),
    .poll_o(poll), .busy_o(busy), .mode_o(mode)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag, logic [2:0] m, logic b, logic [LANES-1:0] p);
    chk({tag, " mode"}, 8'(mode), 8'(m));
    chk({tag, " busy"}, 8'(busy), 8'(b));
    chk({tag, " poll"}, 8'(poll), 8'(p));
  endtask

  // set strobes at a falling edge, clear at the next one; outputs then show the result
  task automatic step(logic p, logic e, logic s, logic r, logic ie, logic ix, logic d);
    pgm = p; ers = e; susp = s; resm = r; iden = ie; idex = ix; done = d;
    @(negedge clk);
    pgm = 0; ers = 0; susp = 0; resm = 0; iden = 0; idex = 0; done = 0;
  endtask

  function automatic logic [LANES*LANE_W-1:0] mk_data(logic [LANES-1:0] m);
    logic [LANES*LANE_W-1:0] d;
    for (int l = 0; l < LANES; l++)
      d[l*LANE_W +: LANE_W] = {m[l], 7'(l * 37 + 5)};
    return d;
  endfunction

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    exp_arr = '1;
    repeat (2) @(negedge clk);
    chk_state("R1 reset", 3'd0, 1'b0, 4'hf);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_state("R1 after release", 3'd0, 1'b0, 4'hf);

    // R2/R3: every MSB pattern
    for (int m = 0; m < 16; m++) begin
      data = mk_data(4'(m));
      step(1, 0, 0, 0, 0, 0, 0);
      chk_state("R2 program", 3'd1, 1'b1, ~4'(m));
      step(0, 1, 0, 0, 0, 0, 0);
      chk("R12 erase during program", 8'(mode), 8'd1);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R7 suspend during program", 8'(mode), 8'd1);
      step(0, 0, 0, 0, 0, 0, 1);
      exp_arr = 4'(m);
      chk_state("R3 program done", 3'd0, 1'b0, exp_arr);
    end

    // R7: suspend/resume in array read ignored
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R7 suspend idle", 8'(mode), 8'd0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R6 resume idle", 8'(mode), 8'd0);

    // R4/R5/R6/R7/R8/R11 erase with suspend cycles
    step(0, 1, 0, 0, 0, 0, 0);
    chk_state("R4 erase", 3'd2, 1'b1, 4'h0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R6 resume while erasing", 8'(mode), 8'd2);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R12 program during erase", 8'(mode), 8'd2);
    step(0, 0, 1, 0, 0, 0, 0);
    chk_state("R5 suspend", 3'd3, 1'b0, 4'hf);
    step(0, 0, 0, 1, 0, 0, 0);
    chk_state("R6 resume", 3'd2, 1'b1, 4'h0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R6 second resume", 8'(mode), 8'd2);
    step(0, 0, 1, 0, 0, 0, 0);
    chk_state("R7 re-suspend", 3'd3, 1'b0, 4'hf);
    prot = 1; data = mk_data(4'h9);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R12 protected program in suspend", 8'(mode), 8'd3);
    prot = 0;
    for (int m = 0; m < 16; m += 5) begin
      data = mk_data(4'(m));
      step(1, 0, 0, 0, 0, 0, 0);
      chk_state("R8 suspended program", 3'd4, 1'b1, ~4'(m));
      step(0, 0, 0, 1, 0, 0, 0);
      chk("R8 resume during program", 8'(mode), 8'd4);
      step(0, 0, 0, 0, 0, 0, 1);
      chk_state("R8 suspended program done", 3'd3, 1'b0, 4'hf);
    end
    step(0, 0, 0, 0, 1, 0, 0);
    chk_state("R11 id enter", 3'd7, 1'b0, 4'hf);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R11 resume in id", 8'(mode), 8'd7);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R11 id exit", 8'(mode), 8'd3);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R6 resume after id", 8'(mode), 8'd2);
    step(0, 0, 0, 0, 0, 0, 1);
    exp_arr = '1;
    chk_state("R4 erase done", 3'd0, 1'b0, 4'hf);

    // R9: protected program window, done held high
    data = mk_data(4'h5); step(1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    exp_arr = 4'h5;
    chk("R3 setup", 8'(poll), 8'h5);
    prot = 1; data = mk_data(4'h3);
    step(1, 0, 0, 0, 0, 0, 0);
    done = 1;
    for (int c = 1; c <= PGM_WIN; c++) begin
      chk_state("R9 protected program window", 3'd5, 1'b1, 4'hc);
      @(negedge clk);
    end
    done = 0;
    chk_state("R9 window end", 3'd0, 1'b0, exp_arr);

    // R10: protected erase window
    step(0, 1, 0, 0, 0, 0, 0);
    for (int c = 1; c <= ERS_WIN; c++) begin
      chk_state("R10 protected erase window", 3'd6, 1'b1, 4'h0);
      @(negedge clk);
    end
    chk_state("R10 window end", 3'd0, 1'b0, exp_arr);
    prot = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule